// File: doc/BRIEF.md
# Chunked Image Staging Sequencer

This block is a host-side engine that copies a firmware image from a word-addressed source memory into a device's register-mapped staging mailbox. It is given the image length in bytes and a start pulse. It resets the mailbox, then sends the image one chunk at a time. Each chunk is framed as a request object and followed by a go command. After each chunk the engine polls the status register until the device is ready. It then reads back a short response, and the device uses that response to name the byte offset it wants next.

The device may ask for a piece it already received, so the number of chunks is not fixed. The engine allows at most twice the image length in sent bytes. When the device returns the all-ones end marker, the engine finishes and reports success. Otherwise it stops at the first fault and reports one encoded error. The result stays on `err_code` until the next start.

The register port carries 32-bit transfers with a byte offset: control at 0x0, status at 0x4, write-data at 0x8 and read-data at 0xC. The source port reads one 32-bit word per handshake.

Top module: `mbox_stager`

## Requirements
- R1: A start with an image length that is not a multiple of 4 ends with `err_code` = 1 and `done` in the next cycle, and no register or source traffic takes place.
- R2: An accepted start first writes 0x0000_0001 to control (0x0). No status read follows this write, and the first chunk starts at offset 0.
- R3: Each chunk is min(CHUNK_BYTES, length − offset) bytes long. Its data words are read from source word offset/4 upward and written in ascending order.
- R4: Before each chunk is framed, the engine checks the budget. If bytes already sent plus the new chunk would exceed twice the length, it ends with `err_code` = 2 and sends no further traffic.
- R5: A request writes these values to write-data (0x8), in this order: {8'h00, 8'h0B, VENDOR_ID}, then (16 + chunk)/4, then 3, then 0, then the chunk words. It then writes 0x8000_0000 to control.
- R6: After the go write, the engine reads status (0x4) once every POLL_WAIT cycles. It stops at the first read with bit 31 set, and it makes at most POLL_LIMIT reads.
- R7: When polling ends, status bit 2 gives `err_code` = 3 (I/O fault). If bit 2 is clear and bit 31 is clear, the result is `err_code` = 4 (timeout).
- R8: The response is read from read-data (0xC) as four words: header low, header high, next offset, status. Each read is followed by a write of 0 to 0xC.
- R9: The response is checked in this order. A header that is not {8'h00, 8'h0B, VENDOR_ID} / 4 gives code 5. An offset that is not 0xFFFF_FFFF and is larger than the length gives code 6. Response status bit 2 gives code 7.
- R10: Offset 0xFFFF_FFFF ends the run with code 0. Any other valid offset starts the next chunk, even one already sent.
- R11: `done` is a one-cycle pulse, and `busy` is high from start until `done`. `err_code` holds its value while idle until the next start.
- R12: A register request holds `reg_valid`, address, direction and write data stable until `reg_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin staging (sampled when idle) |
| img_len | input | 32 | Image length in bytes |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 3 | Result: 0 ok, 1 length, 2 budget, 3 I/O, 4 timeout, 5 header, 6 offset, 7 protocol |
| reg_valid | output | 1 | Register transfer request |
| reg_write | output | 1 | 1 = write, 0 = read |
| reg_addr | output | 4 | Register byte offset |
| reg_wdata | output | 32 | Write data |
| reg_ready | input | 1 | Transfer accepted this cycle |
| reg_rdata | input | 32 | Read data, valid with reg_ready |
| src_valid | output | 1 | Source word request |
| src_word | output | SRC_AW | Source word address |
| src_ready | input | 1 | Source word available this cycle |
| src_data | input | 32 | Source word |

## Verification
The bench models a mailbox device that steers the engine through offsets that revisit earlier chunks and finish on a short tail chunk. A wrong minimum or a wrong address base shows up at once as a mismatched data word. It also runs a device that keeps asking for offset 0 until the budget trips. A design that compared with ≥ instead of > would stop one chunk early, and one that ignored the budget would loop. Other runs never raise ready, raise the fault bit, corrupt the header while also flagging status, or return an offset past the image. In these runs a wrong poll bound, a lost fault bit or a swapped check order gives the wrong code or an extra register transfer. The register ready line toggles, so a request that changes before it is accepted is caught.

// File: rtl/stg_pkg.sv
package stg_pkg;

    localparam int DW = 32;

    localparam logic [3:0] A_CTRL = 4'h0;
    localparam logic [3:0] A_STAT = 4'h4;
    localparam logic [3:0] A_WDAT = 4'h8;
    localparam logic [3:0] A_RDAT = 4'hC;

    localparam logic [7:0]    OBJ_STAGE = 8'h0B;
    localparam logic [DW-1:0] CMD_LOAD  = 32'd3;
    localparam logic [DW-1:0] CTL_ABORT = 32'h0000_0001;
    localparam logic [DW-1:0] CTL_GO    = 32'h8000_0000;
    localparam logic [DW-1:0] END_OFS   = 32'hFFFF_FFFF;
    localparam logic [DW-1:0] RSP_DWORDS = 32'd4;

    typedef enum logic [2:0] {
        ERR_NONE    = 3'd0,
        ERR_LEN     = 3'd1,
        ERR_BUDGET  = 3'd2,
        ERR_IO      = 3'd3,
        ERR_TIMEOUT = 3'd4,
        ERR_HDR     = 3'd5,
        ERR_OFFSET  = 3'd6,
        ERR_PROTO   = 3'd7
    } err_t;

    typedef enum logic [3:0] {
        S_IDLE, S_ABORT, S_PLAN, S_HDR0, S_HDR1, S_CMD0, S_CMD1,
        S_SRC, S_DATA, S_GO, S_WAIT, S_POLL, S_RD, S_ACK, S_CHECK, S_DONE
    } state_t;

endpackage

// File: rtl/stg_chunk_plan.sv
module stg_chunk_plan
    import stg_pkg::*;
#(
    parameter int CHUNK_BYTES = 4096
) (
    input  logic [DW-1:0] len,
    input  logic [DW-1:0] ofs,
    input  logic [DW:0]   sent,
    output logic [DW-1:0] chunk,
    output logic          over_budget
);
    localparam logic [DW-1:0] CAP = DW'(CHUNK_BYTES);

    logic [DW-1:0]   remain;
    logic [DW+1:0]   spend;
    logic [DW+1:0]   limit;

    always_comb begin
        remain      = len - ofs;
        chunk       = (remain > CAP) ? CAP : remain;
        spend       = {1'b0, sent} + {2'b00, chunk};
        limit       = {1'b0, len, 1'b0};
        over_budget = spend > limit;
    end

endmodule

// File: rtl/stg_poll_timer.sv
module stg_poll_timer #(
    parameter int POLL_WAIT  = 250000,
    parameter int POLL_LIMIT = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    input  logic seen,
    output logic wait_done,
    output logic last_poll
);
    localparam int WW = $clog2(POLL_WAIT + 1);
    localparam int PW = $clog2(POLL_LIMIT + 1);

    typedef struct packed {
        logic [WW-1:0] wcnt;
        logic [PW-1:0] pcnt;
    } tmr_t;

    tmr_t t_q, t_d;

    assign wait_done = run && (t_q.wcnt == WW'(POLL_WAIT - 1));
    assign last_poll = (t_q.pcnt == PW'(POLL_LIMIT - 1));

    always_comb begin
        t_d = t_q;
        if (clr) begin
            t_d.wcnt = '0;
            t_d.pcnt = '0;
        end else begin
            if (wait_done)  t_d.wcnt = '0;
            else if (run)   t_d.wcnt = t_q.wcnt + 1'b1;
            if (seen)       t_d.pcnt = t_q.pcnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    // R6: no status read beyond the poll limit
    a_r6_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
        seen |-> (t_q.pcnt < PW'(POLL_LIMIT)));

    // R6: the wait between polls is never shorter than one cycle and restarts after each expiry
    a_r6_wait_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_done && !clr) |=> (t_q.wcnt == '0));

endmodule

// File: rtl/stg_resp_check.sv
module stg_resp_check
    import stg_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID = 16'hC0DE
) (
    input  logic [DW-1:0] rsp_lo,
    input  logic [DW-1:0] rsp_hi,
    input  logic [DW-1:0] rsp_ofs,
    input  logic          rsp_fault,
    input  logic [DW-1:0] len,
    output err_t          verdict,
    output logic          is_end
);
    logic hdr_ok;

    always_comb begin
        hdr_ok  = (rsp_lo == {8'h00, OBJ_STAGE, VENDOR_ID}) && (rsp_hi == RSP_DWORDS);
        is_end  = (rsp_ofs == END_OFS);
        if (!hdr_ok)                    verdict = ERR_HDR;
        else if (!is_end && rsp_ofs > len) verdict = ERR_OFFSET;
        else if (rsp_fault)             verdict = ERR_PROTO;
        else                            verdict = ERR_NONE;
    end

endmodule

// File: rtl/mbox_stager.sv
module mbox_stager
    import stg_pkg::*;
#(
    parameter int          CHUNK_BYTES = 4096,
    parameter int          POLL_WAIT   = 250000,
    parameter int          POLL_LIMIT  = 10000,
    parameter int          SRC_AW      = 16,
    parameter logic [15:0] VENDOR_ID   = 16'hC0DE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       img_len,
    output logic              busy,
    output logic              done,
    output logic [2:0]        err_code,
    output logic              reg_valid,
    output logic              reg_write,
    output logic [3:0]        reg_addr,
    output logic [31:0]       reg_wdata,
    input  logic              reg_ready,
    input  logic [31:0]       reg_rdata,
    output logic              src_valid,
    output logic [SRC_AW-1:0] src_word,
    input  logic              src_ready,
    input  logic [31:0]       src_data
);
    localparam int CW = $clog2(CHUNK_BYTES / 4 + 1);

    typedef struct packed {
        state_t        fsm;
        logic [DW-1:0] len;
        logic [DW-1:0] ofs;
        logic [DW:0]   sent;
        logic [DW-1:0] chunk;
        logic [CW-1:0] widx;
        logic [1:0]    ridx;
        logic [DW-1:0] rsp_lo;
        logic [DW-1:0] rsp_hi;
        logic [DW-1:0] rsp_ofs;
        logic          rsp_fault;
        logic [DW-1:0] wbuf;
        err_t          err;
    } ctx_t;

    ctx_t st_q, st_d;

    logic          fire;
    logic [DW-1:0] plan_chunk;
    logic          plan_over;
    err_t          verdict;
    logic          rsp_end;
    logic          t_clr, t_run, t_seen;
    logic          wait_done, last_poll;
    logic [CW-1:0] words;

    stg_chunk_plan #(.CHUNK_BYTES(CHUNK_BYTES)) i_plan (
        .len        (st_q.len),
        .ofs        (st_q.ofs),
        .sent       (st_q.sent),
        .chunk      (plan_chunk),
        .over_budget(plan_over)
    );

    stg_poll_timer #(.POLL_WAIT(POLL_WAIT), .POLL_LIMIT(POLL_LIMIT)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (t_clr),
        .run      (t_run),
        .seen     (t_seen),
        .wait_done(wait_done),
        .last_poll(last_poll)
    );

    stg_resp_check #(.VENDOR_ID(VENDOR_ID)) i_check (
        .rsp_lo   (st_q.rsp_lo),
        .rsp_hi   (st_q.rsp_hi),
        .rsp_ofs  (st_q.rsp_ofs),
        .rsp_fault(st_q.rsp_fault),
        .len      (st_q.len),
        .verdict  (verdict),
        .is_end   (rsp_end)
    );

    assign words    = CW'(st_q.chunk >> 2);
    assign busy     = (st_q.fsm != S_IDLE);
    assign done     = (st_q.fsm == S_DONE);
    assign err_code = st_q.err;
    assign fire     = reg_valid && reg_ready;
    assign src_valid = (st_q.fsm == S_SRC);
    assign src_word  = SRC_AW'((st_q.ofs >> 2) + DW'(st_q.widx));

    // register port decode
    always_comb begin
        reg_valid = 1'b1;
        reg_write = 1'b1;
        reg_addr  = A_WDAT;
        reg_wdata = '0;
        unique case (st_q.fsm)
            S_ABORT: begin reg_addr = A_CTRL; reg_wdata = CTL_ABORT; end
            S_HDR0:  reg_wdata = {8'h00, OBJ_STAGE, VENDOR_ID};
            S_HDR1:  reg_wdata = 32'd4 + (st_q.chunk >> 2);
            S_CMD0:  reg_wdata = CMD_LOAD;
            S_CMD1:  reg_wdata = '0;
            S_DATA:  reg_wdata = st_q.wbuf;
            S_GO:    begin reg_addr = A_CTRL; reg_wdata = CTL_GO; end
            S_POLL:  begin reg_addr = A_STAT; reg_write = 1'b0; end
            S_RD:    begin reg_addr = A_RDAT; reg_write = 1'b0; end
            S_ACK:   reg_addr = A_RDAT;
            default: begin reg_valid = 1'b0; reg_write = 1'b0; reg_addr = A_CTRL; end
        endcase
    end

    // next-state computation
    always_comb begin
        st_d   = st_q;
        t_clr  = 1'b0;
        t_run  = 1'b0;
        t_seen = 1'b0;
        unique case (st_q.fsm)
            S_IDLE: if (start) begin
                st_d.len  = img_len;
                st_d.ofs  = '0;
                st_d.sent = '0;
                if (img_len[1:0] != 2'b00) begin
                    st_d.err = ERR_LEN;
                    st_d.fsm = S_DONE;
                end else begin
                    st_d.err = ERR_NONE;
                    st_d.fsm = S_ABORT;
                end
            end
            S_ABORT: if (fire) st_d.fsm = S_PLAN;
            S_PLAN: begin
                if (plan_over) begin
                    st_d.err = ERR_BUDGET;
                    st_d.fsm = S_DONE;
                end else begin
                    st_d.chunk = plan_chunk;
                    st_d.widx  = '0;
                    st_d.fsm   = S_HDR0;
                end
            end
            S_HDR0: if (fire) st_d.fsm = S_HDR1;
            S_HDR1: if (fire) st_d.fsm = S_CMD0;
            S_CMD0: if (fire) st_d.fsm = S_CMD1;
            S_CMD1: if (fire) st_d.fsm = (words == '0) ? S_GO : S_SRC;
            S_SRC: if (src_ready) begin
                st_d.wbuf = src_data;
                st_d.fsm  = S_DATA;
            end
            S_DATA: if (fire) begin
                st_d.widx = st_q.widx + 1'b1;
                st_d.fsm  = (st_q.widx + 1'b1 == words) ? S_GO : S_SRC;
            end
            S_GO: if (fire) begin
                st_d.sent = st_q.sent + {1'b0, st_q.chunk};
                t_clr     = 1'b1;
                st_d.fsm  = S_WAIT;
            end
            S_WAIT: begin
                t_run = 1'b1;
                if (wait_done) st_d.fsm = S_POLL;
            end
            S_POLL: if (fire) begin
                t_seen = 1'b1;
                if (reg_rdata[31]) begin
                    if (reg_rdata[2]) begin
                        st_d.err = ERR_IO;
                        st_d.fsm = S_DONE;
                    end else begin
                        st_d.ridx = '0;
                        st_d.fsm  = S_RD;
                    end
                end else if (last_poll) begin
                    st_d.err = reg_rdata[2] ? ERR_IO : ERR_TIMEOUT;
                    st_d.fsm = S_DONE;
                end else begin
                    st_d.fsm = S_WAIT;
                end
            end
            S_RD: if (fire) begin
                unique case (st_q.ridx)
                    2'd0: st_d.rsp_lo    = reg_rdata;
                    2'd1: st_d.rsp_hi    = reg_rdata;
                    2'd2: st_d.rsp_ofs   = reg_rdata;
                    default: st_d.rsp_fault = reg_rdata[2];
                endcase
                st_d.fsm = S_ACK;
            end
            S_ACK: if (fire) begin
                if (st_q.ridx == 2'd3) begin
                    st_d.fsm = S_CHECK;
                end else begin
                    st_d.ridx = st_q.ridx + 1'b1;
                    st_d.fsm  = S_RD;
                end
            end
            S_CHECK: begin
                if (verdict != ERR_NONE) begin
                    st_d.err = verdict;
                    st_d.fsm = S_DONE;
                end else if (rsp_end) begin
                    st_d.fsm = S_DONE;
                end else begin
                    st_d.ofs = st_q.rsp_ofs;
                    st_d.fsm = S_PLAN;
                end
            end
            default: st_d.fsm = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.fsm <= S_IDLE;
            st_q.err <= ERR_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    // R1: a misaligned length finishes at once with the length code and no traffic
    a_r1_bad_len: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fsm == S_IDLE && start && img_len[1:0] != 2'b00)
        |=> (done && err_code == 3'd1 && !reg_valid && !src_valid));

    // R2: an accepted start opens with the abort write to control
    a_r2_abort_first: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fsm == S_IDLE && start && img_len[1:0] == 2'b00)
        |=> (reg_valid && reg_write && reg_addr == A_CTRL && reg_wdata == CTL_ABORT));

    // R3: source reads never fall outside the image
    a_r3_src_inside: assert property (@(posedge clk) disable iff (!rst_n)
        src_valid |-> ((DW'(src_word) << 2) < st_q.len));

    // R11: done lasts one cycle
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: the result stays put while idle
    a_r11_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(err_code));

    // R12: a pending register request does not change before it is accepted
    a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && !reg_ready)
        |=> (reg_valid && $stable(reg_addr) && $stable(reg_write) && $stable(reg_wdata)));

endmodule

// File: tb/test_mbox_stager.sv
module test_mbox_stager;
    localparam int          CHB = 16;
    localparam int          PW  = 3;
    localparam int          PL  = 5;
    localparam int          SAW = 16;
    localparam logic [15:0] VEN = 16'hC0DE;
    localparam logic [31:0] HLO = {8'h00, 8'h0B, VEN};
    localparam logic [31:0] ENDO = 32'hFFFF_FFFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic           start = 1'b0;
    logic [31:0]    img_len = '0;
    logic           busy, done;
    logic [2:0]     err_code;
    logic           reg_valid, reg_write;
    logic [3:0]     reg_addr;
    logic [31:0]    reg_wdata;
    logic           reg_ready = 1'b0;
    logic [31:0]    reg_rdata = '0;
    logic           src_valid;
    logic [SAW-1:0] src_word;
    logic           src_ready;
    logic [31:0]    src_data;

    mbox_stager #(.CHUNK_BYTES(CHB), .POLL_WAIT(PW), .POLL_LIMIT(PL),
                  .SRC_AW(SAW), .VENDOR_ID(VEN)) i_mbox_stager (
        .clk(clk), .rst_n(rst_n), .start(start), .img_len(img_len),
        .busy(busy), .done(done), .err_code(err_code),
        .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_ready(reg_ready), .reg_rdata(reg_rdata),
        .src_valid(src_valid), .src_word(src_word), .src_ready(src_ready),
        .src_data(src_data)
    );

    logic [31:0] mem [0:63];
    initial for (int i = 0; i < 64; i++) mem[i] = 32'hA500_0000 + 32'(i * 7);
    assign src_ready = 1'b1;
    assign src_data  = mem[src_word[5:0]];

    int n_vec = 0;
    int n_bad = 0;

    task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", rq, act, exp);
        end
    endtask

    typedef struct packed { logic we; logic [3:0] a; logic [31:0] d; } txn_t;
    typedef struct packed { logic [31:0] hi; logic [31:0] ofs; logic [31:0] st; } rsp_t;
    txn_t  exp_q[$];
    string tag_q[$];
    rsp_t  rsp_q[$];

    int   ready_after = 0;
    bit   stat_err = 0;
    bit   never_ready = 0;
    int   poll_cnt = 0;
    int   r_i = 0;
    bit   rdy = 0;
    bit   pend = 0;
    txn_t pt;
    txn_t ex;
    string tg;

    function automatic logic [31:0] dev_read(logic [3:0] a);
        logic [31:0] v;
        v = '0;
        if (a == 4'h4) begin
            v = stat_err ? 32'h4 : 32'h0;
            if (!never_ready && poll_cnt >= ready_after) v = v | 32'h8000_0000;
        end else if (a == 4'hC && rsp_q.size() > 0) begin
            case (r_i)
                0: v = HLO;
                1: v = rsp_q[0].hi;
                2: v = rsp_q[0].ofs;
                default: v = rsp_q[0].st;
            endcase
        end
        return v;
    endfunction

    // behavioural device and transaction comparator, one step per clock
    always @(negedge clk) begin
        if (pend) begin
            n_vec++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R12 unexpected transfer act=%h exp=none", pt);
            end else begin
                ex = exp_q.pop_front();
                tg = tag_q.pop_front();
                if (pt.we !== ex.we || pt.a !== ex.a || (ex.we && pt.d !== ex.d)) begin
                    n_bad++;
                    $display("FAIL %s transfer act=%h exp=%h", tg, pt, ex);
                end
            end
            if (!pt.we && pt.a == 4'h4) poll_cnt++;
            if (!pt.we && pt.a == 4'hC) begin
                r_i++;
                if (r_i == 4) begin
                    r_i = 0;
                    if (rsp_q.size() > 0) void'(rsp_q.pop_front());
                end
            end
            if (pt.we && pt.a == 4'h0 && pt.d == 32'h8000_0000) poll_cnt = 0;
        end
        rdy       = ~rdy;
        reg_ready = rdy;
        pend      = 1'b0;
        reg_rdata = '0;
        if (rst_n && reg_valid && rdy) begin
            pend = 1'b1;
            pt   = '{reg_write, reg_addr, reg_wdata};
            if (!reg_write) reg_rdata = dev_read(reg_addr);
        end
    end

    task automatic ew(string t, logic [3:0] a, logic [31:0] d);
        exp_q.push_back('{1'b1, a, d});
        tag_q.push_back(t);
    endtask

    task automatic er(string t, logic [3:0] a);
        exp_q.push_back('{1'b0, a, 32'h0});
        tag_q.push_back(t);
    endtask

    task automatic e_chunk(int off, int len, int nrd);
        int ch;
        ch = (len - off > CHB) ? CHB : len - off;
        ew("R5", 4'h8, HLO);
        ew("R5", 4'h8, 32'(4 + ch / 4));
        ew("R5", 4'h8, 32'd3);
        ew("R5", 4'h8, 32'd0);
        for (int i = 0; i < ch / 4; i++) ew("R3", 4'h8, mem[off / 4 + i]);
        ew("R5", 4'h0, 32'h8000_0000);
        for (int i = 0; i < nrd; i++) er("R6", 4'h4);
    endtask

    task automatic e_rsp();
        for (int i = 0; i < 4; i++) begin
            er("R8", 4'hC);
            ew("R8", 4'hC, 32'h0);
        end
    endtask

    task automatic setup(int ra, bit se, bit nr);
        ready_after = ra;
        stat_err    = se;
        never_ready = nr;
        poll_cnt    = 0;
        r_i         = 0;
        rsp_q.delete();
        exp_q.delete();
        tag_q.delete();
    endtask

    task automatic add_rsp(logic [31:0] hi, logic [31:0] ofs, logic [31:0] st);
        rsp_q.push_back('{hi, ofs, st});
    endtask

    task automatic run(string t, int len, logic [2:0] code);
        int w;
        @(negedge clk);
        start   = 1'b1;
        img_len = 32'(len);
        @(negedge clk);
        start = 1'b0;
        #1;
        chk("R11", {31'b0, busy | done}, 32'd1);
        w = 0;
        while (!done && w < 5000) begin
            @(negedge clk);
            #1;
            w++;
        end
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL %s no done act=0 exp=1", t);
        end
        chk(t, {29'b0, err_code}, {29'b0, code});
        chk(t, 32'(exp_q.size()), 32'd0);
        @(negedge clk);
        #1;
        chk("R11", {30'b0, done, busy}, 32'd0);
    endtask

    bit finished = 0;

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R11", {29'b0, busy, done, reg_valid}, 32'd0);
        chk("R11", {29'b0, err_code}, 32'd0);
        chk("R3", {31'b0, src_valid}, 32'd0);
        rst_n = 1'b1;

        // R1: misaligned length, no traffic at all
        setup(0, 0, 0);
        run("R1", 42, 3'd1);

        // R10: plain forward walk, short tail chunk
        setup(2, 0, 0);
        ew("R2", 4'h0, 32'h1);
        e_chunk(0, 40, 3);  e_rsp(); add_rsp(32'd4, 32'd16, 32'h1);
        e_chunk(16, 40, 3); e_rsp(); add_rsp(32'd4, 32'd32, 32'h1);
        e_chunk(32, 40, 3); e_rsp(); add_rsp(32'd4, ENDO, 32'h1);
        run("R10", 40, 3'd0);

        // R10: device asks for earlier pieces again, still within budget (72 of 80)
        setup(0, 0, 0);
        ew("R2", 4'h0, 32'h1);
        e_chunk(0, 40, 1);  e_rsp(); add_rsp(32'd4, 32'd16, 32'h0);
        e_chunk(16, 40, 1); e_rsp(); add_rsp(32'd4, 32'd0, 32'h0);
        e_chunk(0, 40, 1);  e_rsp(); add_rsp(32'd4, 32'd16, 32'h0);
        e_chunk(16, 40, 1); e_rsp(); add_rsp(32'd4, 32'd32, 32'h0);
        e_chunk(32, 40, 1); e_rsp(); add_rsp(32'd4, ENDO, 32'h0);
        run("R10", 40, 3'd0);

        // R4: length 24, device always wants 0; 48 is allowed, 64 is not
        setup(1, 0, 0);
        ew("R2", 4'h0, 32'h1);
        for (int k = 0; k < 3; k++) begin
            e_chunk(0, 24, 2); e_rsp(); add_rsp(32'd4, 32'd0, 32'h0);
        end
        run("R4", 24, 3'd2);

        // R7: ready never rises, exactly the poll limit of reads
        setup(0, 0, 1);
        ew("R2", 4'h0, 32'h1);
        e_chunk(0, 8, PL);
        run("R7", 8, 3'd4);

        // R7: fault bit with ready
        setup(1, 1, 0);
        ew("R2", 4'h0, 32'h1);
        e_chunk(0, 8, 2);
        run("R7", 8, 3'd3);

        // R9: bad header wins over a faulting status
        setup(0, 0, 0);
        ew("R2", 4'h0, 32'h1);
        e_chunk(0, 8, 1); e_rsp(); add_rsp(32'd5, ENDO, 32'h4);
        run("R9", 8, 3'd5);

        // R9: offset past the image end
        setup(0, 0, 0);
        ew("R2", 4'h0, 32'h1);
        e_chunk(0, 8, 1); e_rsp(); add_rsp(32'd4, 32'd12, 32'h0);
        run("R9", 8, 3'd6);

        // R9: response status fault
        setup(0, 0, 0);
        ew("R2", 4'h0, 32'h1);
        e_chunk(0, 8, 1); e_rsp(); add_rsp(32'd4, ENDO, 32'h4);
        run("R9", 8, 3'd7);

        // R11: code stays while idle
        repeat (10) @(negedge clk);
        #1;
        chk("R11", {29'b0, err_code}, 32'd7);
        chk("R12", 32'(exp_q.size()), 32'd0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule